// File: doc/BRIEF.md
# Delayed Special Cycle Completion Responder

This block is the target-side half of a bridge path that turns a qualifying configuration write into a special cycle on the far bus and completes it as a delayed transaction. The first attempt of such a write is latched into a single entry and answered with retry. The latched request is then offered to the far-side master on a valid/ready request stream. The address and data are passed through as they are, and the command is rewritten to the special-cycle code.

The far-side master reports with a single pulse that the cycle has ended. A special cycle always ends in master abort, so this pulse always means success, and nothing about the abort reaches the initiator. Until that pulse, every claimed attempt is retried. After it, the first repeat attempt that equals the latched request in address, command and data is answered with target ready. If that attempt asks for more than one data phase, stop is raised together with ready, so that only one transfer takes place. The entry is then freed.

Attempts enter on a valid/ready stream. `att_ready` is low in any cycle in which a response is on the outputs, so at most one attempt is accepted every two cycles. An attempt held with `att_valid` high while `att_ready` is low waits and is not lost. Each accepted attempt gets exactly one response one cycle later (`rsp_valid`), and that response cannot be stalled. The far-side request holds `fwd_valid` and its payload steady until `fwd_ready` is seen.

Top module: `dsc_responder`

## Requirements
- R1: After reset, `rsp_valid` and `fwd_valid` are 0 and `att_ready` is 1.
- R2: An attempt is claimed only if all of the following hold: the command is 4'hB (configuration write), addr[1:0]=01, addr[7:2]=0, addr[10:8]=111, addr[15:11]=11111 and addr[16+:BUSW] equals `tgt_bus`. Any other attempt gets a response with `rsp_claim`, `rsp_trdy` and `rsp_stop` all 0, and it leaves the state unchanged.
- R3: A claimed attempt while idle is answered with retry (claim=1, trdy=0, stop=1) and latched. From the next cycle `fwd_valid` is 1, with `fwd_cmd`=4'h1 (special cycle) and `fwd_addr`/`fwd_data` equal to the attempt's address and data.
- R4: `fwd_valid` and its payload stay stable while `fwd_ready` is 0. `fwd_valid` drops in the cycle after the handshake.
- R5: Every claimed attempt made before the far-side completion pulse has been registered is retried, including exact repeats and an attempt in the same cycle as the pulse.
- R6: After a completion pulse, a matching repeat attempt completes without any error indication.
- R7: That completion is claim=1, trdy=1, stop=0 when `att_multi` is 0.
- R8: When `att_multi` is 1, the completion is claim=1, trdy=1, stop=1 (disconnect with the first data).
- R9: A claimed attempt that differs from the entry in address or data is retried, and the entry is kept, so a later matching attempt still completes.
- R10: After a completing transfer the block is idle again. The same request is then treated as new: it is retried and forwarded again.
- R11: An accepted attempt (`att_valid` and `att_ready`) produces `rsp_valid` one cycle later, and `att_ready` is 0 while `rsp_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tgt_bus | input | BUSW | Bus number that a claimed attempt must carry |
| att_valid | input | 1 | Attempt presented |
| att_ready | output | 1 | Attempt can be accepted |
| att_addr | input | AW | Attempt address |
| att_cmd | input | 4 | Attempt bus command |
| att_data | input | DW | Attempt first data word |
| att_multi | input | 1 | Attempt requests more than one data phase |
| rsp_valid | output | 1 | Response to the attempt accepted one cycle earlier |
| rsp_claim | output | 1 | Attempt was claimed |
| rsp_trdy | output | 1 | Target ready (transfer completes) |
| rsp_stop | output | 1 | Stop (retry without trdy, disconnect with trdy) |
| fwd_valid | output | 1 | Special cycle request to far-side master |
| fwd_ready | input | 1 | Far-side master takes the request |
| fwd_addr | output | AW | Forwarded address |
| fwd_data | output | DW | Forwarded data |
| fwd_cmd | output | 4 | Forwarded command (special cycle) |
| far_done | input | 1 | One-cycle pulse: far cycle ended (master abort) |

## Verification
Two functions can meet in the same cycle: the far-side completion pulse and a matching repeat attempt. The bench raises `far_done` on exactly the edge on which it presents that attempt. Because the attempt is judged against the state as it stood at that edge, the expected answer is retry. The very next matching attempt must then complete with ready. The decode sweep flips every address bit of the qualifying pattern and tries every command code, both while idle and while the completion is pending, to make sure none of them is claimed.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  localparam int          CMD_W       = 4;
  localparam logic [3:0]  CMD_CFG_WR  = 4'hB;
  localparam logic [3:0]  CMD_SPECIAL = 4'h1;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_DONE} st_e;

  typedef struct packed {
    logic claim;
    logic trdy;
    logic stop;
  } rsp_t;
endpackage

// File: rtl/dsc_decode.sv
module dsc_decode #(
  parameter int AW   = 32,
  parameter int BUSW = 8
) (
  input  logic [AW-1:0]           addr,
  input  logic [dsc_pkg::CMD_W-1:0] cmd,
  input  logic [BUSW-1:0]         tgt_bus,
  output logic                    hit
);
  localparam int BUS_LSB = 16;
  logic kind_ok, reg_ok, fn_ok, dev_ok, bus_ok;

  always_comb begin
    kind_ok = (addr[1:0] == 2'b01);
    reg_ok  = (addr[7:2] == 6'd0);
    fn_ok   = &addr[10:8];
    dev_ok  = &addr[15:11];
    bus_ok  = (addr[BUS_LSB +: BUSW] == tgt_bus);
    hit     = (cmd == dsc_pkg::CMD_CFG_WR) && kind_ok && reg_ok && fn_ok && dev_ok && bus_ok;
  end
endmodule

// File: rtl/dsc_entry.sv
module dsc_entry #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic                      clear,
  input  logic [AW-1:0]             in_addr,
  input  logic [dsc_pkg::CMD_W-1:0] in_cmd,
  input  logic [DW-1:0]             in_data,
  output logic [AW-1:0]             e_addr,
  output logic [DW-1:0]             e_data,
  output logic                      match
);
  logic                      e_valid;
  logic [dsc_pkg::CMD_W-1:0] e_cmd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_valid <= 1'b0;
      e_addr  <= '0;
      e_data  <= '0;
      e_cmd   <= '0;
    end else if (load) begin
      e_valid <= 1'b1;
      e_addr  <= in_addr;
      e_data  <= in_data;
      e_cmd   <= in_cmd;
    end else if (clear) begin
      e_valid <= 1'b0;
    end
  end

  always_comb
    match = e_valid && (in_addr == e_addr) && (in_data == e_data) && (in_cmd == e_cmd);
endmodule

// File: rtl/dsc_ctrl.sv
module dsc_ctrl (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc,
  input  logic            hit,
  input  logic            match,
  input  logic            multi,
  input  logic            fwd_ready,
  input  logic            far_done,
  output logic            load,
  output logic            clear,
  output logic            fwd_valid,
  output dsc_pkg::rsp_t   rsp_d
);
  import dsc_pkg::*;
  st_e st_q, st_d;

  always_comb begin
    load  = 1'b0;
    clear = 1'b0;
    rsp_d = '0;
    st_d  = st_q;
    if (acc && hit) begin
      rsp_d.claim = 1'b1;
      rsp_d.stop  = 1'b1;
      if (st_q == ST_IDLE) begin
        load = 1'b1;
        st_d = ST_ISSUE;
      end else if (st_q == ST_DONE && match) begin
        rsp_d.trdy = 1'b1;
        rsp_d.stop = multi;
        clear      = 1'b1;
        st_d       = ST_IDLE;
      end
    end
    if (st_q == ST_ISSUE && fwd_ready) st_d = ST_WAIT;
    if (st_q == ST_WAIT && far_done)   st_d = ST_DONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_comb fwd_valid = (st_q == ST_ISSUE);
endmodule

// File: rtl/dsc_responder.sv
module dsc_responder #(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int BUSW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [BUSW-1:0] tgt_bus,
  input  logic            att_valid,
  output logic            att_ready,
  input  logic [AW-1:0]   att_addr,
  input  logic [3:0]      att_cmd,
  input  logic [DW-1:0]   att_data,
  input  logic            att_multi,
  output logic            rsp_valid,
  output logic            rsp_claim,
  output logic            rsp_trdy,
  output logic            rsp_stop,
  output logic            fwd_valid,
  input  logic            fwd_ready,
  output logic [AW-1:0]   fwd_addr,
  output logic [DW-1:0]   fwd_data,
  output logic [3:0]      fwd_cmd,
  input  logic            far_done
);
  import dsc_pkg::*;

  logic acc, hit, match, load, clear;
  rsp_t rsp_d, rsp_q;
  logic rsp_v_q;

  dsc_decode #(.AW(AW), .BUSW(BUSW)) dec_i (
    .addr(att_addr), .cmd(att_cmd), .tgt_bus(tgt_bus), .hit(hit)
  );

  dsc_entry #(.AW(AW), .DW(DW)) ent_i (
    .clk(clk), .rst_n(rst_n), .load(load), .clear(clear),
    .in_addr(att_addr), .in_cmd(att_cmd), .in_data(att_data),
    .e_addr(fwd_addr), .e_data(fwd_data), .match(match)
  );

  dsc_ctrl ctl_i (
    .clk(clk), .rst_n(rst_n), .acc(acc), .hit(hit), .match(match),
    .multi(att_multi), .fwd_ready(fwd_ready), .far_done(far_done),
    .load(load), .clear(clear), .fwd_valid(fwd_valid), .rsp_d(rsp_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_v_q <= 1'b0;
      rsp_q   <= '0;
    end else begin
      rsp_v_q <= acc;
      rsp_q   <= acc ? rsp_d : '0;
    end
  end

  always_comb begin
    att_ready = !rsp_v_q;
    acc       = att_valid && att_ready;
    rsp_valid = rsp_v_q;
    rsp_claim = rsp_q.claim;
    rsp_trdy  = rsp_q.trdy;
    rsp_stop  = rsp_q.stop;
    fwd_cmd   = CMD_SPECIAL;
  end
endmodule

// File: rtl/dsc_responder_chk.sv
module dsc_responder_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          att_valid,
  input logic          att_ready,
  input logic          rsp_valid,
  input logic          rsp_claim,
  input logic          rsp_trdy,
  input logic          rsp_stop,
  input logic          fwd_valid,
  input logic          fwd_ready,
  input logic [AW-1:0] fwd_addr,
  input logic [DW-1:0] fwd_data,
  input logic [3:0]    fwd_cmd
);
  // R11
  accept_gives_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (att_valid && att_ready) |=> rsp_valid);
  // R11
  no_accept_during_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !att_ready);
  // R4
  fwd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && !fwd_ready) |=> (fwd_valid && $stable(fwd_addr) && $stable(fwd_data)));
  // R4
  fwd_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && fwd_ready) |=> !fwd_valid);
  // R2
  unclaimed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_claim) |-> (!rsp_trdy && !rsp_stop));
  // R5
  retry_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_claim && !rsp_trdy) |-> rsp_stop);
  // R3
  fwd_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> (fwd_cmd == 4'h1));
endmodule

bind dsc_responder dsc_responder_chk #(.AW(AW), .DW(DW)) chk_i (.*);

// File: tb/dsc_responder_tb_top.sv
`timescale 1ns/1ps
module dsc_responder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  tgt_bus = 8'h5A;
  logic        att_valid = 1'b0, att_multi = 1'b0;
  logic [31:0] att_addr = '0, att_data = '0;
  logic [3:0]  att_cmd = '0;
  logic        att_ready, rsp_valid, rsp_claim, rsp_trdy, rsp_stop;
  logic        fwd_valid, fwd_ready = 1'b0, far_done = 1'b0;
  logic [31:0] fwd_addr, fwd_data;
  logic [3:0]  fwd_cmd;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  dsc_responder #(.AW(32), .DW(32), .BUSW(8)) dut_i (.*);

  localparam logic [31:0] QA = {8'h00, 8'h5A, 5'h1F, 3'h7, 6'h00, 2'b01};

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic attempt(input logic [31:0] a, input logic [3:0] c, input logic [31:0] d,
                         input logic m, input logic pd, output logic [2:0] r);
    @(negedge clk);
    while (!att_ready) @(negedge clk);
    att_addr = a; att_cmd = c; att_data = d; att_multi = m; att_valid = 1'b1;
    far_done = pd;
    @(negedge clk);
    att_valid = 1'b0; far_done = 1'b0;
    r = {rsp_claim, rsp_trdy, rsp_stop};
    check(rsp_valid == 1'b1, "R11", "rsp_valid", rsp_valid, 1);
    check(att_ready == 1'b0, "R11", "att_ready", att_ready, 0);
  endtask

  task automatic sweep_decode(input string tag);
    logic [2:0] r;
    for (int i = 0; i < 24; i++) begin
      attempt(QA ^ (32'd1 << i), 4'hB, 32'h0, 1'b0, 1'b0, r);
      check(r == 3'b000, "R2", tag, r, 0);
    end
    for (int c = 0; c < 16; c++) begin
      if (c != 11) begin
        attempt(QA, 4'(c), 32'h0, 1'b0, 1'b0, r);
        check(r == 3'b000, "R2", tag, r, 0);
      end
    end
  endtask

  task automatic forward_and_finish(input logic [31:0] d);
    @(negedge clk);
    check(fwd_valid == 1'b1, "R3", "fwd_valid", fwd_valid, 1);
    check(fwd_cmd == 4'h1, "R3", "fwd_cmd", fwd_cmd, 1);
    check(fwd_addr == QA, "R3", "fwd_addr", fwd_addr, QA);
    check(fwd_data == d, "R3", "fwd_data", fwd_data, d);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(fwd_valid && fwd_addr == QA, "R4", "hold", fwd_valid, 1);
    end
    fwd_ready = 1'b1;
    @(negedge clk);
    fwd_ready = 1'b0;
    check(fwd_valid == 1'b0, "R4", "drop", fwd_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [2:0] r;
    repeat (3) @(negedge clk);
    check(!rsp_valid && !fwd_valid && att_ready, "R1", "reset outs",
          {rsp_valid, fwd_valid, att_ready}, 3'b001);
    rst_n = 1'b1;
    sweep_decode("idle unclaimed");
    @(negedge clk);
    check(fwd_valid == 1'b0, "R2", "no fwd after unclaimed", fwd_valid, 0);

    attempt(QA, 4'hB, 32'hC0DE_0001, 1'b0, 1'b0, r);
    check(r == 3'b101, "R3", "first attempt retry", r, 3'b101);
    attempt(QA, 4'hB, 32'hC0DE_0001, 1'b0, 1'b0, r);
    check(r == 3'b101, "R5", "repeat before handshake", r, 3'b101);
    forward_and_finish(32'hC0DE_0001);
    attempt(QA, 4'hB, 32'hC0DE_0001, 1'b0, 1'b0, r);
    check(r == 3'b101, "R5", "repeat while waiting", r, 3'b101);
    attempt(QA, 4'hB, 32'hC0DE_0001, 1'b0, 1'b1, r);
    check(r == 3'b101, "R5", "same cycle as done", r, 3'b101);
    sweep_decode("done unclaimed");
    attempt(QA, 4'hB, 32'hC0DE_0002, 1'b0, 1'b0, r);
    check(r == 3'b101, "R9", "data mismatch retry", r, 3'b101);
    attempt(QA | 32'h0100_0000, 4'hB, 32'hC0DE_0001, 1'b0, 1'b0, r);
    check(r == 3'b101, "R9", "addr mismatch retry", r, 3'b101);
    attempt(QA, 4'hB, 32'hC0DE_0001, 1'b0, 1'b0, r);
    check(r == 3'b110, "R6", "completion after abort", r, 3'b110);
    check(r == 3'b110, "R7", "single completion", r, 3'b110);

    attempt(QA, 4'hB, 32'hC0DE_0001, 1'b1, 1'b0, r);
    check(r == 3'b101, "R10", "idle again retry", r, 3'b101);
    forward_and_finish(32'hC0DE_0001);
    @(negedge clk); far_done = 1'b1;
    @(negedge clk); far_done = 1'b0;
    attempt(QA, 4'hB, 32'hC0DE_0001, 1'b1, 1'b0, r);
    check(r == 3'b111, "R8", "multi disconnect", r, 3'b111);
    @(negedge clk);
    check(fwd_valid == 1'b0, "R10", "no fwd after complete", fwd_valid, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule